// File: doc/BRIEF.md
# Bus Data Parity Generator and Checker

This block produces and checks even parity on a 32-bit data bus split into four byte lanes, each with its own parity bit. For writes it turns the outgoing write data into four parity bits in the same cycle, with no register in the path, so they travel alongside the data.

For reads it evaluates the incoming data and parity on the clock edge at which ready is high. One clock later it presents the result on an active-low status line, counting only the lanes whose active-low byte enable is asserted.

A three-bit cycle-type code decides whether a read is checked. Code, memory and I/O reads are checked. Interrupt acknowledge and every other code are not. The read data passes through unchanged whatever the parity result, because an error is reported and never acted upon.

Top module: `bus_parity_unit`

## Requirements
- R1: In every cycle, wr_par[i] makes the nine bits {wr_data[8i+7:8i], wr_par[i]} hold an even count of ones, combinationally from the same cycle's wr_data.
- R2: A read lane is in error when its eight data bits rd_data[8i+7:8i] together with rd_par[i] hold an odd count of ones.
- R3: After a clock edge with rst low, rdy high and a checked cycle type, par_stat_n is low for the following cycle exactly when at least one enabled lane is in error, and high otherwise.
- R4: Only the cycle-type codes 3'b000 (code read), 3'b001 (memory read) and 3'b010 (I/O read) are checked. Memory write 3'b011, I/O write 3'b100, interrupt acknowledge 3'b101 and codes 3'b110 and 3'b111 never drive par_stat_n low.
- R5: A ready edge with cycle type 3'b101 (interrupt acknowledge) leaves par_stat_n high in the next cycle, even when enabled lanes carry bad parity.
- R6: A lane whose be_n[i] is 1 is ignored: bad parity on it alone leaves par_stat_n high.
- R7: par_stat_n is high after any clock edge with rst high, and after any edge without rdy high.
- R8: rd_data_out equals rd_data in every cycle, whether the parity is good or bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_type | input | 3 | Bus cycle type code |
| rdy | input | 1 | Transfer ready; the read is sampled on the edge at which it is high |
| be_n | input | 4 | Active-low byte enables, bit i for lane i |
| wr_data | input | 32 | Outgoing write data |
| wr_par | output | 4 | Even parity bits for wr_data, one per lane |
| rd_data | input | 32 | Incoming read data |
| rd_par | input | 4 | Incoming read parity bits |
| rd_data_out | output | 32 | Read data passed onward unchanged |
| par_stat_n | output | 1 | Parity status, low for one cycle after a checked read with an enabled lane in error |

## Verification
The checker is tried with single-lane faults on each lane in turn, both enabled and disabled. This separates the per-lane mask from the error OR and shows whether each lane reaches the result. The same faulty data is also presented under every cycle-type code, which tells checked reads apart from writes, interrupt acknowledge and the unused codes. Clean reads, ready-low cycles and reset cycles show that the status returns high. A long random run compares write parity, data pass-through and the delayed status against a behavioural model on every clock.

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CT_W   = 3,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CT_W-1:0]  cyc_type,
  input  logic             rdy,
  input  logic [LANES-1:0] be_n,
  input  logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] wr_par,
  input  logic [DW-1:0]    rd_data,
  input  logic [LANES-1:0] rd_par,
  output logic [DW-1:0]    rd_data_out,
  output logic             par_stat_n
);
  localparam logic [CT_W-1:0] CT_CODE_RD = CT_W'(0);
  localparam logic [CT_W-1:0] CT_MEM_RD  = CT_W'(1);
  localparam logic [CT_W-1:0] CT_IO_RD   = CT_W'(2);

  logic [LANES-1:0] lane_bad;
  logic             rd_checked;
  logic             rd_fault;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_par[g]   = ^wr_data[g*LANE_W +: LANE_W];
    assign lane_bad[g] = ^{rd_data[g*LANE_W +: LANE_W], rd_par[g]};
  end

  assign rd_checked  = (cyc_type == CT_CODE_RD) || (cyc_type == CT_MEM_RD) ||
                       (cyc_type == CT_IO_RD);
  assign rd_fault    = |(lane_bad & ~be_n);
  assign rd_data_out = rd_data;

  always_ff @(posedge clk) begin
    if (rst)                    par_stat_n <= 1'b1;
    else if (rdy && rd_checked) par_stat_n <= ~rd_fault;
    else                        par_stat_n <= 1'b1;
  end
endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CT_W   = 3,
  localparam int DW    = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic [CT_W-1:0]  cyc_type,
  input logic             rdy,
  input logic [LANES-1:0] be_n,
  input logic [DW-1:0]    wr_data,
  input logic [LANES-1:0] wr_par,
  input logic [DW-1:0]    rd_data,
  input logic [LANES-1:0] rd_par,
  input logic [DW-1:0]    rd_data_out,
  input logic             par_stat_n
);
  function automatic logic all_even(input logic [DW-1:0] d, input logic [LANES-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++)
      if ($countones({d[i*LANE_W +: LANE_W], p[i]}) % 2 != 0) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic enabled_bad(input logic [DW-1:0] d, input logic [LANES-1:0] p,
                                       input logic [LANES-1:0] m_n);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (!m_n[i] && ($countones({d[i*LANE_W +: LANE_W], p[i]}) % 2 != 0)) bad = 1'b1;
    return bad;
  endfunction

  logic is_rd;
  assign is_rd = (int'(cyc_type) < 3);

  // R1
  a_r1_wr_even: assert property (@(posedge clk) disable iff (rst) all_even(wr_data, wr_par));
  // R8
  a_r8_passthru: assert property (@(posedge clk) disable iff (rst) rd_data_out == rd_data);
  // R3, R2, R6
  a_r3_err_low: assert property (@(posedge clk) disable iff (rst)
    (rdy && is_rd && enabled_bad(rd_data, rd_par, be_n)) |=> !par_stat_n);
  a_r3_ok_high: assert property (@(posedge clk) disable iff (rst)
    (rdy && is_rd && !enabled_bad(rd_data, rd_par, be_n)) |=> par_stat_n);
  // R4
  a_r4_unchecked: assert property (@(posedge clk) disable iff (rst)
    (rdy && !is_rd) |=> par_stat_n);
  // R5
  a_r5_inta: assert property (@(posedge clk) disable iff (rst)
    (rdy && cyc_type == CT_W'(5)) |=> par_stat_n);
  // R7
  a_r7_idle: assert property (@(posedge clk) disable iff (rst) !rdy |=> par_stat_n);
  a_r7_reset: assert property (@(posedge clk) rst |=> par_stat_n);
endmodule

bind bus_parity_unit bus_parity_unit_chk #(.LANES(LANES), .LANE_W(LANE_W), .CT_W(CT_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_type(cyc_type), .rdy(rdy), .be_n(be_n),
  .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data), .rd_par(rd_par),
  .rd_data_out(rd_data_out), .par_stat_n(par_stat_n));

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cyc_type;
  logic        rdy;
  logic [3:0]  be_n;
  logic [31:0] wr_data;
  logic [3:0]  wr_par;
  logic [31:0] rd_data;
  logic [3:0]  rd_par;
  logic [31:0] rd_data_out;
  logic        par_stat_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_parity_unit u_dut (
    .clk(clk), .rst(rst), .cyc_type(cyc_type), .rdy(rdy), .be_n(be_n),
    .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data), .rd_par(rd_par),
    .rd_data_out(rd_data_out), .par_stat_n(par_stat_n));

  function automatic int ones(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [3:0] model_wpar(input logic [31:0] d);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) p[l] = (ones({1'b0, d[8*l +: 8]}) % 2 == 1);
    return p;
  endfunction

  function automatic logic model_stat(input logic r, input logic [2:0] ct, input logic k,
                                      input logic [3:0] m_n, input logic [31:0] d,
                                      input logic [3:0] p);
    bit fault = 0;
    if (r || !k || ct > 3'd2) return 1'b1;
    for (int l = 0; l < 4; l++)
      if (!m_n[l] && (ones({d[8*l +: 8], p[l]}) % 2 == 1)) fault = 1;
    return !fault;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic r, input logic [2:0] ct, input logic k,
                       input logic [3:0] m_n, input logic [31:0] wd, input logic [31:0] d,
                       input logic [3:0] p);
    logic es;
    rst = r; cyc_type = ct; rdy = k; be_n = m_n; wr_data = wd; rd_data = d; rd_par = p;
    #1;
    check("R1 wr_par", {28'd0, wr_par}, {28'd0, model_wpar(wd)});
    check("R8 rd_data_out", rd_data_out, d);
    es = model_stat(r, ct, k, m_n, d, p);
    @(posedge clk);
    @(negedge clk);
    check(tag, {31'd0, par_stat_n}, {31'd0, es});
  endtask

  initial begin
    logic [31:0] good;
    logic [3:0]  gp;
    rst = 1'b1; cyc_type = 3'd7; rdy = 1'b0; be_n = 4'hF;
    wr_data = '0; rd_data = '0; rd_par = '0;
    @(negedge clk);
    cycle("R7 reset", 1'b1, 3'd1, 1'b1, 4'h0, 32'h0, 32'h0000_0001, 4'h0);
    cycle("R7 reset", 1'b1, 3'd0, 1'b1, 4'h0, 32'h0, 32'h0000_0001, 4'h0);
    good = 32'hA5_3C_07_FF;
    gp   = model_wpar(good);
    cycle("R3 clean read", 1'b0, 3'd1, 1'b1, 4'h0, 32'h1234_5678, good, gp);
    cycle("R2 all-zero lanes", 1'b0, 3'd0, 1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0, 4'h0);
    for (int l = 0; l < 4; l++) begin
      cycle("R2 lane fault enabled", 1'b0, 3'd2, 1'b1, 4'h0, good, good, gp ^ (4'h1 << l));
      cycle("R6 lane fault masked", 1'b0, 3'd1, 1'b1, 4'h1 << l, good, good, gp ^ (4'h1 << l));
      cycle("R6 other lane masked", 1'b0, 3'd0, 1'b1, ~(4'h1 << l), good, good,
            gp ^ (4'hF & ~(4'h1 << l)));
    end
    for (int c = 0; c < 8; c++) begin
      if (c == 5) cycle("R5 int ack", 1'b0, 3'(c), 1'b1, 4'h0, good, good, ~gp);
      else        cycle("R4 cycle code", 1'b0, 3'(c), 1'b1, 4'h0, good, good, ~gp);
    end
    cycle("R7 no ready", 1'b0, 3'd1, 1'b0, 4'h0, good, good, ~gp);
    cycle("R3 back-to-back bad", 1'b0, 3'd1, 1'b1, 4'h0, good, good, ~gp);
    cycle("R3 back-to-back bad", 1'b0, 3'd2, 1'b1, 4'hE, good, good, gp ^ 4'h1);
    cycle("R7 after error", 1'b0, 3'd3, 1'b0, 4'h0, good, good, gp);
    for (int n = 0; n < 2000; n++) begin
      cycle("R3 random", ($urandom_range(0, 31) == 0), 3'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), 4'($urandom), $urandom, $urandom, 4'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule